// File: doc/BRIEF.md
# Swept Chirp Waveform Generator

This block synthesises, sample by sample, the frequency-swept chirp that serves as the carrier of a spread-spectrum line transceiver. It produces one signed 8-bit word for an external DAC on every cycle of a 12 MHz clock. A command port starts one symbol at a time. The symbol is silence, a chirp in phase 1, or the same chirp turned through 180° (phase 2), which gives the phase-reversal keying of the packet body. Every chirp lasts 100 µs and sweeps in two halves. The upper band (about 200 kHz up to 400 kHz) comes first, then the lower band (100 kHz up to 200 kHz).

A 24-bit phase accumulator drives a 64-entry quarter-wave sine table. The accumulator is cleared at the start of every symbol. Its increment ramps linearly on every clock, and the ramp restarts at the segment boundary, which falls halfway through the chirp. In preamble mode each symbol gets a 14 µs silent tail, for a 114 µs symbol. A one-cycle done pulse marks the last cycle of each symbol. A start raised in that cycle chains the next symbol without a gap.

Top module: `chirp_gen`

## Requirements
- R1: After synchronous reset, and whenever no symbol is running, `valid_o` and `done_o` are 0 and `sample_o` is 0.
- R2: A start (`start_i`=1) taken while idle makes `valid_o` high from the next cycle on. Outside preamble mode, `valid_o` then stays high for exactly 1200 consecutive cycles (100 µs at 12 MHz).
- R3: With `pre_i`=1 at the start, the symbol lasts 1368 cycles. The last 168 samples (14 µs) are 0.
- R4: Symbol code 0 (quiet) gives `sample_o`=0 for the whole symbol, with `valid_o` high.
- R5: Symbol code 1 (phase 1): in chirp cycle n, the phase P(n) is the sum of the increments of cycles 0..n-1, modulo 2^24, with P(0)=0. `sample_o`, read as two's complement, lies within ±3 of 127·sin(2π·P(n)/2^24) and is never 0.
- R6: Let inc(f) = floor(f·2^24/12e6). The increment for cycle n is inc(200k) + n·floor((inc(400k)-inc(200k))/600) for n<600. It is inc(100k) + (n-600)·floor((inc(200k)-inc(100k))/600) for 600≤n<1200. The upper band is therefore swept first.
- R7: Symbol code 2 (phase 2) uses the phase P(n)+2^23, which is the phase-1 chirp inverted by 180°. The same tolerance as in R5 applies.
- R8: `done_o` is high for exactly one cycle, the last cycle of the symbol. A start in that cycle begins the next symbol in the following cycle, so `valid_o` stays high.
- R9: A start during a running symbol, other than in its done cycle, is ignored. The running symbol keeps its code, mode and length.
- R10: Symbol code 3 behaves as quiet (all-zero samples for the full symbol length).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 12 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for one symbol |
| sym_i | input | 2 | Symbol code: 0 quiet, 1 phase 1, 2 phase 2, 3 quiet |
| pre_i | input | 1 | Preamble mode: add the 14 µs silent tail |
| sample_o | output | 8 | Signed sample word for the DAC |
| valid_o | output | 1 | High during every cycle of a symbol |
| done_o | output | 1 | One-cycle pulse in the last cycle of a symbol |

## Verification
Phase-1 and phase-2 chirps are run both with and without the preamble tail. Comparing them shows whether the 180° offset is applied, and whether the tail is silent and has the right length. A quiet symbol and a code-3 symbol check that no tone leaks from an invalid or inferior command. Symbols chained from the done cycle check that the accumulator and the ramp restart with no gap cycle. A start strobe in the middle of a symbol, carrying a different code, checks that a busy generator ignores it. A per-cycle phase model compares every sample against a sine within a small tolerance. This shows whether the sweep order, the ramp steps and the segment restart are right.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        SYM_QUIET = 2'd0,
        SYM_PH1   = 2'd1,
        SYM_PH2   = 2'd2,
        SYM_RSVD  = 2'd3
    } sym_e;

    typedef struct packed {
        logic tone;
        logic invert;
        logic pre;
    } sym_ctl_t;

    function automatic int inc_of(input longint freq_hz, input longint clk_hz, input int acc_w);
        longint scaled;
        scaled = (freq_hz << acc_w) / clk_hz;
        return int'(scaled);
    endfunction

    // Rational sine approximation sampled at bin midpoints of a quarter wave.
    function automatic int quarter_mag(input int idx, input int addr_w, input int amp);
        longint n, k, p, den;
        n   = longint'(1) << (addr_w + 2);
        k   = 2 * longint'(idx) + 1;
        p   = k * (n - k);
        den = 5 * n * n - 4 * p;
        return int'((16 * longint'(amp) * p + den / 2) / den);
    endfunction

    function automatic sym_ctl_t decode_sym(input sym_e code, input logic pre);
        sym_ctl_t c;
        c.tone   = (code == SYM_PH1) || (code == SYM_PH2);
        c.invert = (code == SYM_PH2);
        c.pre    = pre;
        return c;
    endfunction

endpackage

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_pkg::*;
#(
    parameter int CHIRP_CYC = 1200,
    parameter int TAIL_CYC  = 168,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       sym_i,
    input  logic             pre_i,
    output logic             load_o,
    output logic             active_o,
    output logic             tone_o,
    output logic             invert_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST_PLAIN = CNT_W'(CHIRP_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_PRE   = CNT_W'(CHIRP_CYC + TAIL_CYC - 1);
    localparam logic [CNT_W-1:0] CHIRP_END  = CNT_W'(CHIRP_CYC);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    sym_ctl_t         ctl_q;
    logic [CNT_W-1:0] last;

    assign last     = ctl_q.pre ? LAST_PRE : LAST_PLAIN;
    assign done_o   = active_q && (cnt_q == last);
    assign load_o   = start_i && (!active_q || done_o);
    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign tone_o   = active_q && ctl_q.tone && (cnt_q < CHIRP_END);
    assign invert_o = ctl_q.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            ctl_q    <= '0;
        end else if (load_o) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            ctl_q    <= decode_sym(sym_e'(sym_i), pre_i);
        end else if (active_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done_o) begin
                active_q <= 1'b0;
            end
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (active_q && !done_o && start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/chirp_nco.sv
module chirp_nco #(
    parameter int ACC_W     = 24,
    parameter int CNT_W     = 11,
    parameter int CHIRP_CYC = 1200,
    parameter int INC_MID   = 279620,
    parameter int INC_LO    = 139810,
    parameter int INC_HI    = 559240,
    parameter int STEP_A    = 466,
    parameter int STEP_B    = 233
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [ACC_W-1:0] phase_o
);

    localparam int HALF = CHIRP_CYC / 2;
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] SEAM_CNT = CNT_W'(HALF - 1);
    localparam logic [ACC_W-1:0] MID_V    = ACC_W'(INC_MID);
    localparam logic [ACC_W-1:0] LO_V     = ACC_W'(INC_LO);
    localparam logic [ACC_W-1:0] HI_V     = ACC_W'(INC_HI);
    localparam logic [ACC_W-1:0] STEP_A_V = ACC_W'(STEP_A);
    localparam logic [ACC_W-1:0] STEP_B_V = ACC_W'(STEP_B);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W-1:0] inc_next;

    always_comb begin
        if (cnt_i == SEAM_CNT) begin
            inc_next = LO_V;
        end else if (cnt_i < HALF_CNT) begin
            inc_next = inc_q + STEP_A_V;
        end else begin
            inc_next = inc_q + STEP_B_V;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            inc_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            inc_q <= MID_V;
        end else if (run_i) begin
            acc_q <= acc_q + inc_q;
            inc_q <= inc_next;
        end
    end

    assign phase_o = acc_q;

    a_r6_inc_range: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (inc_q >= LO_V) && (inc_q <= HI_V));

    a_r5_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (phase_o == '0));

endmodule

// File: rtl/chirp_sine.sv
module chirp_sine
    import chirp_pkg::*;
#(
    parameter int ACC_W  = 24,
    parameter int OUT_W  = 8,
    parameter int LUT_AW = 6
) (
    input  logic             [ACC_W-1:0] phase_i,
    input  logic                         invert_i,
    input  logic                         enable_i,
    output logic signed      [OUT_W-1:0] sample_o
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam int MAG_W = OUT_W - 1;
    localparam int AMP   = (1 << MAG_W) - 1;
    localparam logic [ACC_W-1:0] HALF_TURN = ACC_W'(1) << (ACC_W - 1);

    logic [MAG_W-1:0] tbl [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_tbl
        assign tbl[g] = MAG_W'(quarter_mag(g, LUT_AW, AMP));
    end

    logic [ACC_W-1:0]        ph;
    logic [1:0]              quad;
    logic [LUT_AW-1:0]       idx;
    logic signed [OUT_W-1:0] pos;

    always_comb begin
        ph   = invert_i ? (phase_i + HALF_TURN) : phase_i;
        quad = ph[ACC_W-1 -: 2];
        idx  = ph[ACC_W-3 -: LUT_AW];
        if (quad[0]) begin
            idx = ~idx;
        end
        pos = $signed({1'b0, tbl[idx]});
        if (!enable_i) begin
            sample_o = '0;
        end else if (quad[1]) begin
            sample_o = -pos;
        end else begin
            sample_o = pos;
        end
    end

endmodule

// File: rtl/chirp_gen.sv
module chirp_gen
    import chirp_pkg::*;
#(
    parameter int CLK_HZ    = 12_000_000,
    parameter int ACC_W     = 24,
    parameter int OUT_W     = 8,
    parameter int LUT_AW    = 6,
    parameter int CHIRP_CYC = 1200,
    parameter int TAIL_CYC  = 168,
    parameter int F_LO_HZ   = 100_000,
    parameter int F_MID_HZ  = 200_000,
    parameter int F_HI_HZ   = 400_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       sym_i,
    input  logic             pre_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam int CNT_W   = $clog2(CHIRP_CYC + TAIL_CYC);
    localparam int INC_LO  = inc_of(F_LO_HZ, CLK_HZ, ACC_W);
    localparam int INC_MID = inc_of(F_MID_HZ, CLK_HZ, ACC_W);
    localparam int INC_HI  = inc_of(F_HI_HZ, CLK_HZ, ACC_W);
    localparam int STEP_A  = (INC_HI - INC_MID) / (CHIRP_CYC / 2);
    localparam int STEP_B  = (INC_MID - INC_LO) / (CHIRP_CYC / 2);

    logic             load;
    logic             active;
    logic             tone;
    logic             invert;
    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] phase;
    logic signed [OUT_W-1:0] wave;

    chirp_seq #(
        .CHIRP_CYC (CHIRP_CYC),
        .TAIL_CYC  (TAIL_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sym_i    (sym_i),
        .pre_i    (pre_i),
        .load_o   (load),
        .active_o (active),
        .tone_o   (tone),
        .invert_o (invert),
        .done_o   (done_o),
        .cnt_o    (cnt)
    );

    chirp_nco #(
        .ACC_W     (ACC_W),
        .CNT_W     (CNT_W),
        .CHIRP_CYC (CHIRP_CYC),
        .INC_MID   (INC_MID),
        .INC_LO    (INC_LO),
        .INC_HI    (INC_HI),
        .STEP_A    (STEP_A),
        .STEP_B    (STEP_B)
    ) u_nco (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .run_i   (tone),
        .cnt_i   (cnt),
        .phase_o (phase)
    );

    chirp_sine #(
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .LUT_AW (LUT_AW)
    ) u_sine (
        .phase_i  (phase),
        .invert_i (invert),
        .enable_i (tone),
        .sample_o (wave)
    );

    assign sample_o = wave;
    assign valid_o  = active;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (sample_o == '0) && !done_o);

    a_r2_end_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_o) |-> $past(done_o));

    a_r5_tone_nonzero: assert property (@(posedge clk) disable iff (rst)
        tone |-> (sample_o != '0));

endmodule

// File: tb/chirp_gen_tb.sv
`timescale 1ns/1ps
module chirp_gen_tb;

    localparam int CHIRP = 1200;
    localparam int TAIL  = 168;
    localparam int TOL   = 3;
    localparam real TWO_PI = 6.283185307179586;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] sym_i = 2'd0;
    logic       pre_i = 1'b0;
    logic [7:0] sample_o;
    logic       valid_o;
    logic       done_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit busy_phase = 1'b0;

    // reference model state
    bit     m_active = 1'b0;
    int     m_cnt = 0;
    int     m_len = 0;
    int     m_code = 0;
    longint m_acc = 0;
    longint m_inc = 0;

    longint INC_LO, INC_MID, INC_HI, STEP_A, STEP_B;

    chirp_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .sym_i    (sym_i),
        .pre_i    (pre_i),
        .sample_o (sample_o),
        .valid_o  (valid_o),
        .done_o   (done_o)
    );

    always #4 clk = ~clk;

    function automatic longint f2inc(input longint f);
        return (f * 64'd16777216) / 64'd12000000;
    endfunction

    function automatic bit m_done();
        return m_active && (m_cnt == m_len - 1);
    endfunction

    initial begin
        INC_LO  = f2inc(100000);
        INC_MID = f2inc(200000);
        INC_HI  = f2inc(400000);
        STEP_A  = (INC_HI - INC_MID) / 600;
        STEP_B  = (INC_MID - INC_LO) / 600;
    end

    always @(posedge clk) begin
        bit accept;
        cycles <= cycles + 1;
        if (rst) begin
            m_active = 1'b0;
            m_cnt = 0;
        end else begin
            accept = start_i && (!m_active || m_done());
            if (m_active) begin
                if (m_cnt < CHIRP) begin
                    m_acc = (m_acc + m_inc) % 64'd16777216;
                    if (m_cnt < 599) m_inc = m_inc + STEP_A;
                    else if (m_cnt == 599) m_inc = INC_LO;
                    else m_inc = m_inc + STEP_B;
                end
                if (m_done()) m_active = 1'b0;
                m_cnt = m_cnt + 1;
            end
            if (accept) begin
                m_active = 1'b1;
                m_cnt = 0;
                m_acc = 0;
                m_inc = INC_MID;
                m_code = int'(sym_i);
                m_len = pre_i ? CHIRP + TAIL : CHIRP;
            end
        end
    end

    function automatic string sample_tag();
        if (!m_active) return "R1";
        if (busy_phase) return "R9";
        if (m_code == 3) return "R10";
        if (m_cnt >= CHIRP) return "R3";
        if (m_code == 0) return "R4";
        if (m_code == 2) return "R7";
        if (m_cnt >= 600) return "R6";
        return "R5";
    endfunction

    always @(negedge clk) begin
        bit bad;
        int act;
        real expv;
        longint ph;
        if (!rst) begin
            bad = 1'b0;
            act = int'($signed(sample_o));
            compared++;
            if (valid_o !== m_active) begin
                bad = 1'b1;
                $display("FAIL R2 valid cnt=%0d actual=%0b expected=%0b", m_cnt, valid_o, m_active);
            end
            if (done_o !== m_done()) begin
                bad = 1'b1;
                $display("FAIL R8 done cnt=%0d actual=%0b expected=%0b", m_cnt, done_o, m_done());
            end
            if (m_active && (m_code == 1 || m_code == 2) && m_cnt < CHIRP) begin
                ph = (m_code == 2) ? (m_acc + 64'd8388608) % 64'd16777216 : m_acc;
                expv = 127.0 * $sin(TWO_PI * real'(ph) / 16777216.0);
                if (act == 0 || real'(act) > expv + TOL || real'(act) < expv - TOL) begin
                    bad = 1'b1;
                    $display("FAIL %s sample cnt=%0d actual=%0d expected=%0f", sample_tag(), m_cnt, act, expv);
                end
            end else if (act != 0) begin
                bad = 1'b1;
                $display("FAIL %s sample cnt=%0d actual=%0d expected=0", sample_tag(), m_cnt, act);
            end
            if (bad) mismatched++;
        end
    end

    task automatic pulse(input int code, input bit pre);
        start_i = 1'b1;
        sym_i = 2'(code);
        pre_i = pre;
        @(negedge clk);
        start_i = 1'b0;
        sym_i = 2'd0;
        pre_i = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_active);
    endtask

    task automatic wait_done_cycle();
        do @(negedge clk); while (!m_done());
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compared++;
        if (valid_o !== 1'b0 || done_o !== 1'b0 || sample_o !== 8'd0) begin
            mismatched++;
            $display("FAIL R1 reset state actual=%0b%0b/%0d expected=00/0", valid_o, done_o, sample_o);
        end
        // R5 R6: phase-1 plain chirp
        pulse(1, 1'b0);
        wait_idle();
        repeat (3) @(negedge clk);
        // R7 R3: phase-2 with preamble tail
        pulse(2, 1'b1);
        wait_idle();
        // R4: quiet symbol
        pulse(0, 1'b0);
        wait_idle();
        // R8: chained symbols from the done cycle
        pulse(1, 1'b1);
        wait_done_cycle();
        pulse(0, 1'b1);
        wait_done_cycle();
        pulse(2, 1'b0);
        wait_idle();
        // R9: start while busy is ignored
        pulse(1, 1'b0);
        busy_phase = 1'b1;
        repeat (300) @(negedge clk);
        pulse(2, 1'b1);
        repeat (500) @(negedge clk);
        pulse(0, 1'b0);
        wait_idle();
        busy_phase = 1'b0;
        // R10: reserved code behaves as quiet
        pulse(3, 1'b1);
        wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 150000);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
        finish_run();
    end

endmodule